// File: doc/BRIEF.md
# Serial Field Delay Memory with Refresh Arbitration

This block is a scaled-down behavioural model of a serial-access field memory, such as one used to delay a video field. Words enter serially on a write stream. They leave serially on a read stream. Each side has its own position pointer, and each pointer is returned to position zero by its own reset strobe. Storage is an array of rows. Each row holds one block of `BLK` words. Words never move one at a time between the serial ports and the array. The write side gathers a block in a staging register. The read side fetches a whole row into a read register.

A single slot arbiter grants at most one array access per cycle. It chooses among three requests: committing a staged write block, loading the read register, and refreshing the row named by a free-running refresh counter. A written block is held back until one further block has been written after it, and only then is it committed to the array. This delay creates the old-data/new-data behaviour of a field memory:

- A read that starts close behind the writer returns the previous field.
- A read that trails the writer by two blocks or more returns the field being written.

Top module: `field_delay_mem`

## Requirements
- R1: While `rst_n` is low, `rd_valid` is 0, `wr_ready` is 1 (with `wr_rst` low) and `ref_row` is 0.
- R2: A word is taken when `wr_valid` and `wr_ready` are both high. `wr_ready` is low in any cycle where `wr_rst` is high. It is also low when the offered word would complete a block while both the held block and the pending block are still occupied.
- R3: After `rd_rst`, accepted reads return positions 0, 1, 2, … in order. Each word read is the word last committed at that position. A completed block is committed once the next block has been written. A pulse of `wr_rst` also commits the block that was last completed.
- R4: If `rd_rst` follows `wr_rst` by at most 20 write positions and both sides then stream, the reads return the previous field's data.
- R5: If the read pointer trails the write pointer by 40 positions or more when it enters a block, the read returns the new field's data. This includes a lag of exactly 40, with `rd_rst` asserted in the cycle of the 40th write.
- R6: If `rd_rst` comes before `wr_rst` and both sides then stream, the reads return the previous field's data.
- R7: `grant` shows the one access performed in each cycle, encoded as 0 idle, 1 refresh, 2 write commit, 3 read load. The order of priority is:
  1. an overdue refresh;
  2. a pending write commit;
  3. a read load;
  4. a refresh that is due but not yet overdue.
- R8: A refresh falls due every `REF_PERIOD` cycles and becomes overdue after `REF_SLACK` further cycles. When nothing else competes, refresh grants are exactly `REF_PERIOD` cycles apart. Each refresh grant advances `ref_row` by one, modulo `NBLK`.
- R9: Read back-pressure works as follows:
  - While `rd_valid` is high and `rd_ready` is low, the read pointer holds and `rd_data` does not change.
  - After the last word of a block is read, `rd_valid` is low in the next cycle until the next row is loaded.
- R10: Both pointers wrap from position `NBLK*BLK-1` to position 0. A read that runs past the end returns position 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_rst | input | 1 | Returns the write pointer to position 0 and flushes the last completed block |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word can be taken |
| wr_data | input | W | Write word |
| rd_rst | input | 1 | Returns the read pointer to position 0 and drops the read register |
| rd_valid | output | 1 | Read word at the current position is available |
| rd_ready | input | 1 | Consumer takes the read word |
| rd_data | output | W | Read word at the current position |
| grant | output | 2 | Array access in this cycle (0 idle, 1 refresh, 2 write, 3 read) |
| ref_row | output | clog2(NBLK) | Row the refresh counter points at |

## Verification
The hardest case to reach from the ports is the exact 40-position boundary. There, a block commit and the read load of the same row become ready in the same cycle, and only the write-before-read priority makes the new data win. The stimulus reaches this case as follows:
- It streams one word per cycle into a fresh field.
- It pulses `rd_rst` in the very cycle that accepts the 40th word.
- It keeps both streams running, so every later row entry happens with a lag of at least 40.

The zero-to-20 and reset-read-first cases use the same streaming task with a different alignment of the reset strobes. Any block entry that falls in the 21 to 39 window is reported as a warning, not checked.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE    = 2'd0,
    SLOT_REFRESH = 2'd1,
    SLOT_WRITE   = 2'd2,
    SLOT_READ    = 2'd3
  } slot_t;
endpackage

// File: rtl/fdm_wr_port.sv
module fdm_wr_port #(
  parameter int W    = 8,
  parameter int BLK  = 20,
  parameter int NBLK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rst,
  input  logic              wr_valid,
  input  logic [W-1:0]      wr_data,
  output logic              wr_ready,
  output logic              commit_req,
  output logic [$clog2(NBLK)-1:0] commit_row,
  output logic [W*BLK-1:0]  commit_data,
  input  logic              commit_ack
);
  localparam int OW   = $clog2(BLK);
  localparam int RW   = $clog2(NBLK);
  localparam int ROWB = W * BLK;

  logic [OW-1:0]   woff;
  logic [RW-1:0]   wrow;
  logic [W-1:0]    fbuf [BLK];
  logic            h_vld, h_due, p_vld;
  logic [RW-1:0]   h_row, p_row;
  logic [ROWB-1:0] h_data, p_data, full_row;
  logic            last, fire;

  assign last     = (woff == OW'(BLK - 1));
  assign wr_ready = !wr_rst && !(last && h_vld && p_vld);
  assign fire     = wr_valid && wr_ready;

  // the completed row: staged words plus the word arriving now
  always_comb begin
    full_row = '0;
    for (int i = 0; i < BLK; i++)
      full_row[i*W +: W] = (OW'(i) == woff) ? wr_data : fbuf[i];
  end

  always_ff @(posedge clk)
    if (fire) fbuf[woff] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      woff  <= '0;
      wrow  <= '0;
      h_vld <= 1'b0;
      h_due <= 1'b0;
      p_vld <= 1'b0;
    end else begin
      if (commit_ack) p_vld <= 1'b0;
      if (wr_rst) begin
        woff <= '0;
        wrow <= '0;
        if (h_vld) h_due <= 1'b1;
      end else if (fire && last) begin
        woff   <= '0;
        wrow   <= (wrow == RW'(NBLK - 1)) ? '0 : wrow + RW'(1);
        h_vld  <= 1'b1;
        h_due  <= 1'b0;
        h_row  <= wrow;
        h_data <= full_row;
        if (h_vld) begin
          p_vld  <= 1'b1;
          p_row  <= h_row;
          p_data <= h_data;
        end
      end else if (fire) begin
        woff <= woff + OW'(1);
      end
      // held block released by a reset-write once the pending stage is free
      if (!(fire && last) && h_vld && h_due && !p_vld) begin
        p_vld  <= 1'b1;
        p_row  <= h_row;
        p_data <= h_data;
        h_vld  <= 1'b0;
        h_due  <= 1'b0;
      end
    end
  end

  assign commit_req  = p_vld;
  assign commit_row  = p_row;
  assign commit_data = p_data;
endmodule

// File: rtl/fdm_rd_port.sv
module fdm_rd_port #(
  parameter int W    = 8,
  parameter int BLK  = 20,
  parameter int NBLK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_rst,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [W-1:0]      rd_data,
  output logic              load_req,
  output logic [$clog2(NBLK)-1:0] load_row,
  input  logic              load_ack,
  input  logic [W*BLK-1:0]  load_data
);
  localparam int OW   = $clog2(BLK);
  localparam int RW   = $clog2(NBLK);
  localparam int ROWB = W * BLK;

  logic [OW-1:0]   roff;
  logic [RW-1:0]   rrow, rb_row;
  logic            rb_vld;
  logic [ROWB-1:0] rbuf;
  logic            fire;

  assign rd_valid = rb_vld && (rb_row == rrow);
  assign load_req = !rd_valid;
  assign load_row = rrow;
  assign fire     = rd_valid && rd_ready && !rd_rst;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < BLK; i++)
      if (OW'(i) == roff) rd_data = rbuf[i*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roff   <= '0;
      rrow   <= '0;
      rb_vld <= 1'b0;
      rb_row <= '0;
    end else if (rd_rst) begin
      roff   <= '0;
      rrow   <= '0;
      rb_vld <= 1'b0;
    end else begin
      if (load_ack) begin
        rb_vld <= 1'b1;
        rb_row <= rrow;
        rbuf   <= load_data;
      end
      if (fire) begin
        if (roff == OW'(BLK - 1)) begin
          roff <= '0;
          rrow <= (rrow == RW'(NBLK - 1)) ? '0 : rrow + RW'(1);
        end else begin
          roff <= roff + OW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fdm_refresh.sv
module fdm_refresh #(
  parameter int NBLK       = 8,
  parameter int REF_PERIOD = 64,
  parameter int REF_SLACK  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_ack,
  output logic                    ref_req,
  output logic                    ref_urgent,
  output logic [$clog2(NBLK)-1:0] ref_row
);
  localparam int CW = $clog2(REF_PERIOD);
  localparam int AW = $clog2(REF_SLACK + 1);
  localparam int RW = $clog2(NBLK);

  logic [CW-1:0] cnt;
  logic [AW-1:0] age;
  logic          pend, tick;

  assign tick       = (cnt == CW'(REF_PERIOD - 1));
  assign ref_req    = pend;
  assign ref_urgent = pend && (age == AW'(REF_SLACK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      age     <= '0;
      pend    <= 1'b0;
      ref_row <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (ref_ack) begin
        pend    <= 1'b0;
        ref_row <= (ref_row == RW'(NBLK - 1)) ? '0 : ref_row + RW'(1);
      end else if (pend && age != AW'(REF_SLACK)) begin
        age <= age + AW'(1);
      end
      if (tick) begin
        pend <= 1'b1;
        age  <= '0;
      end
    end
  end
endmodule

// File: rtl/fdm_arbiter.sv
module fdm_arbiter
  import fdm_pkg::*;
(
  input  logic  ref_urgent,
  input  logic  ref_req,
  input  logic  wr_req,
  input  logic  rd_req,
  output slot_t slot,
  output logic  ref_ack,
  output logic  wr_ack,
  output logic  rd_ack
);
  always_comb begin
    if (ref_urgent)   slot = SLOT_REFRESH;
    else if (wr_req)  slot = SLOT_WRITE;
    else if (rd_req)  slot = SLOT_READ;
    else if (ref_req) slot = SLOT_REFRESH;
    else              slot = SLOT_IDLE;
  end

  assign ref_ack = (slot == SLOT_REFRESH);
  assign wr_ack  = (slot == SLOT_WRITE);
  assign rd_ack  = (slot == SLOT_READ);
endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem
  import fdm_pkg::*;
#(
  parameter int W          = 8,
  parameter int BLK        = 20,
  parameter int NBLK       = 8,
  parameter int REF_PERIOD = 64,
  parameter int REF_SLACK  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_rst,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [W-1:0]            wr_data,
  input  logic                    rd_rst,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [W-1:0]            rd_data,
  output logic [1:0]              grant,
  output logic [$clog2(NBLK)-1:0] ref_row
);
  localparam int RW   = $clog2(NBLK);
  localparam int ROWB = W * BLK;

  logic            commit_req, commit_ack;
  logic [RW-1:0]   commit_row;
  logic [ROWB-1:0] commit_data;
  logic            load_req, load_ack;
  logic [RW-1:0]   load_row;
  logic [ROWB-1:0] load_data;
  logic            ref_req, ref_urgent, ref_ack;
  slot_t           slot;

  logic [ROWB-1:0] cells [NBLK];

  always_ff @(posedge clk)
    if (commit_ack) cells[commit_row] <= commit_data;

  assign load_data = cells[load_row];
  assign grant     = slot;

  fdm_wr_port #(.W(W), .BLK(BLK), .NBLK(NBLK)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .commit_req(commit_req),
    .commit_row(commit_row), .commit_data(commit_data), .commit_ack(commit_ack)
  );

  fdm_rd_port #(.W(W), .BLK(BLK), .NBLK(NBLK)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_rst(rd_rst), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .load_req(load_req),
    .load_row(load_row), .load_ack(load_ack), .load_data(load_data)
  );

  fdm_refresh #(.NBLK(NBLK), .REF_PERIOD(REF_PERIOD), .REF_SLACK(REF_SLACK)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ref_row(ref_row)
  );

  fdm_arbiter u_arb (
    .ref_urgent(ref_urgent), .ref_req(ref_req), .wr_req(commit_req),
    .rd_req(load_req), .slot(slot), .ref_ack(ref_ack), .wr_ack(commit_ack),
    .rd_ack(load_ack)
  );
endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
  parameter int W          = 8,
  parameter int NBLK       = 8,
  parameter int REF_PERIOD = 64,
  parameter int REF_SLACK  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_rst,
  input logic                    wr_ready,
  input logic                    rd_rst,
  input logic                    rd_ready,
  input logic                    rd_valid,
  input logic [W-1:0]            rd_data,
  input logic [1:0]              grant,
  input logic [$clog2(NBLK)-1:0] ref_row,
  input logic                    wr_req,
  input logic                    ref_urgent
);
  localparam int RW    = $clog2(NBLK);
  localparam int LIMIT = REF_PERIOD + REF_SLACK + 2;
  localparam int GW    = $clog2(LIMIT + 1) + 1;

  function automatic logic [RW-1:0] step_row(input logic [RW-1:0] r);
    return (r == RW'(NBLK - 1)) ? '0 : r + RW'(1);
  endfunction

  logic [GW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (grant == 2'd1) gap <= '0;
    else if (gap != {GW{1'b1}}) gap <= gap + GW'(1);
  end

  // R2
  wr_rst_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |-> !wr_ready);

  // R7
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> grant == 2'd1);

  // R7
  wr_over_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !ref_urgent) |-> grant == 2'd2);

  // R8
  ref_row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'd1) |=> ref_row == step_row($past(ref_row)));

  // R8
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= GW'(LIMIT));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !rd_rst) |=> (rd_valid && $stable(rd_data)));
endmodule

bind field_delay_mem fdm_checker #(
  .W(W), .NBLK(NBLK), .REF_PERIOD(REF_PERIOD), .REF_SLACK(REF_SLACK)
) u_fdm_chk (
  .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .wr_ready(wr_ready),
  .rd_rst(rd_rst), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .rd_data(rd_data), .grant(grant), .ref_row(ref_row),
  .wr_req(commit_req), .ref_urgent(ref_urgent)
);

// File: tb/tb_field_delay_mem.sv
`timescale 1ns/1ps
module tb_field_delay_mem;
  localparam int W     = 8;
  localparam int BLK   = 20;
  localparam int NBLK  = 8;
  localparam int DEPTH = BLK * NBLK;
  localparam int RP    = 64;
  localparam int RS    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_rst = 1'b0, wr_valid = 1'b0, rd_rst = 1'b0, rd_ready = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic wr_ready, rd_valid;
  logic [W-1:0] rd_data;
  logic [1:0] grant;
  logic [$clog2(NBLK)-1:0] ref_row;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  field_delay_mem #(.W(W), .BLK(BLK), .NBLK(NBLK), .REF_PERIOD(RP), .REF_SLACK(RS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_rst(rd_rst),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .grant(grant), .ref_row(ref_row)
  );

  function automatic logic [W-1:0] pat(input int f, input int p);
    return W'(f * 37 + p * 5 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_valid = 0; rd_ready = 0; wr_rst = 0; rd_rst = 0;
    end
  endtask

  task automatic pulse_wr_rst();
    @(negedge clk);
    wr_rst = 1; wr_valid = 1; wr_data = '0; rd_ready = 0; rd_rst = 0;
    #1 chk(wr_ready == 1'b0, "R2 ready during reset-write", int'(wr_ready), 0);
    @(negedge clk);
    wr_rst = 0; wr_valid = 0;
  endtask

  task automatic pulse_rd_rst();
    @(negedge clk);
    rd_rst = 1; rd_ready = 0; wr_valid = 0; wr_rst = 0;
    @(negedge clk);
    rd_rst = 0;
  endtask

  // concurrent write of field wf and read expecting field rf
  task automatic stream(input int wf, input int nw, input int rf, input int nr,
                        input int rd_at, input string req);
    int wc = 0;
    int rc = 0;
    bit rd_on = (rd_at < 0);
    while (wc < nw || rc < nr) begin
      @(negedge clk);
      wr_rst   = 0;
      wr_valid = (wc < nw);
      wr_data  = pat(wf, wc);
      rd_rst   = (!rd_on && wc == rd_at);
      rd_ready = rd_on && (rc < nr);
      #1;
      if (rd_ready && rd_valid) begin
        if (rc % BLK == 0 && (wc - rc) > 20 && (wc - rc) < 40)
          $display("WARN lag %0d at read position %0d is in the undefined window", wc - rc, rc);
        chk(rd_data == pat(rf, rc % DEPTH), req, int'(rd_data), int'(pat(rf, rc % DEPTH)));
        rc++;
      end
      if (wr_valid && wr_ready) wc++;
      if (rd_rst) rd_on = 1;
    end
    @(negedge clk);
    wr_valid = 0; rd_ready = 0; rd_rst = 0;
  endtask

  task automatic read_field(input int f, input int nr, input int stall_at);
    int rc = 0;
    int stall = 5;
    bit after_last = 0;
    pulse_rd_rst();
    while (rc < nr) begin
      @(negedge clk);
      rd_ready = !(rc == stall_at && stall > 0);
      #1;
      if (after_last) begin
        chk(rd_valid == 1'b0, "R9 bubble after block end", int'(rd_valid), 0);
        after_last = 0;
      end
      if (!rd_ready) begin
        chk(rd_valid && rd_data == pat(f, rc), "R9 word held under back-pressure",
            int'(rd_data), int'(pat(f, rc)));
        stall--;
      end else if (rd_valid) begin
        chk(rd_data == pat(f, rc % DEPTH), (rc >= DEPTH) ? "R10 wrap" : "R3 ordered read",
            int'(rd_data), int'(pat(f, rc % DEPTH)));
        if (rc % BLK == BLK - 1) after_last = 1;
        rc++;
      end
    end
    @(negedge clk);
    rd_ready = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(rd_valid == 1'b0, "R1 rd_valid in reset", int'(rd_valid), 0);
    chk(wr_ready == 1'b1, "R1 wr_ready in reset", int'(wr_ready), 1);
    chk(ref_row == '0, "R1 ref_row in reset", int'(ref_row), 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_fill_and_read();
    pulse_wr_rst();
    stream(1, DEPTH, 0, 0, -1, "R3");
    pulse_wr_rst();
    idle(4);
    read_field(1, DEPTH, -1);
  endtask

  task automatic t_old_close_behind();
    pulse_wr_rst();
    stream(2, DEPTH, 1, 60, 5, "R4 old data at small lag");
    pulse_wr_rst();
    idle(4);
  endtask

  task automatic t_new_at_forty();
    // R7: the commit of row 0 and its read load collide; write wins
    pulse_wr_rst();
    stream(3, DEPTH, 3, 80, 39, "R5 new data at lag 40");
    pulse_wr_rst();
    idle(4);
  endtask

  task automatic t_read_first();
    pulse_rd_rst();
    idle(2);
    pulse_wr_rst();
    stream(4, DEPTH, 3, 60, -1, "R6 old data when reset-read leads");
    pulse_wr_rst();
    idle(4);
  endtask

  task automatic t_stall_and_wrap();
    read_field(4, DEPTH + 10, 3);
  endtask

  task automatic t_refresh();
    int last = -1;
    int cnt = 0;
    bit pend_row = 0;
    logic [$clog2(NBLK)-1:0] exp_row = '0;
    idle(5);
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      #1;
      if (pend_row) begin
        chk(ref_row == exp_row, "R8 ref_row step", int'(ref_row), int'(exp_row));
        pend_row = 0;
      end
      if (grant == 2'd1) begin
        if (last >= 0) chk(cyc - last == RP, "R8 refresh spacing", cyc - last, RP);
        last = cyc;
        cnt++;
        exp_row = (int'(ref_row) == NBLK - 1) ? '0 : ref_row + 1'b1;
        pend_row = 1;
      end
    end
    chk(cnt >= 4, "R8 refresh count", cnt, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_and_read();
    t_old_close_behind();
    t_new_at_forty();
    t_read_first();
    t_stall_and_wrap();
    t_refresh();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule